// File: doc/BRIEF.md
# Split Lag Accumulator with Snapshot Buffer

This block accumulates signed sample increments for one correlator lag. The running total is held in two parts: a narrow low section and a wide upper counter. Each accepted sample adds +1, +3, -1 or -3, decoded from a three-bit sign/magnitude/valid code. Any carry or borrow out of the low section moves the upper counter. After such a carry the upper counter is treated as unsettled for a fixed number of cycles, and a busy flag shows that window.

A load command copies the upper counter into a snapshot buffer, which is the block's result output. A clear command zeroes the upper counter only; the low section keeps its value. Load and clear can each come from an internal source that acts at once, or from an external board input that arrives through a two-stage delay. A per-command select input picks the source. A load is never executed while the counter is unsettled: it waits until busy falls. A clear that meets a waiting or same-cycle load is applied together with that load, so the buffer receives the value before the clear.

Top module: `lag_accum_top`

## Requirements
- R1: `code_i` is {sign (bit 2), magnitude (bit 1), valid (bit 0)}. Code 001 adds +1, 011 adds +3, 101 adds -1 and 111 adds -3. The total is a 27-bit two's-complement value equal to upper*8 + low.
- R2: The total changes only on cycles where `acc_en_i` is high and the valid bit is 1. Codes 010, 100 and 110 change nothing and raise no flag.
- R3: Code 000 with `acc_en_i` high sets `err_o` at the next edge and is not accumulated. `err_o` then stays high until reset.
- R4: A carry or borrow out of the low 3 bits changes the upper counter by ±1 at the same edge. `busy_o` is high for exactly the 2 cycles after that edge, and a new carry restarts the window.
- R5: A clear sets the upper counter to zero and leaves the low 3 bits unchanged. A carry from a sample in the same cycle is added onto the zeroed counter.
- R6: A load executes at an edge where `busy_o` is low and copies the pre-edge upper counter to `buf_o`. The new value is visible after that edge, and `buf_o` holds its value otherwise.
- R7: A load requested while `busy_o` is high is kept pending. It executes at the first edge with `busy_o` low.
- R8: A clear that arrives while a load is pending, or in the same cycle as a load that must wait, is held. It executes at the same edge as that load, so `buf_o` receives the value before the clear.
- R9: With `ld_sel_ext_i` or `clr_sel_ext_i` high, the internal command input is ignored. The external input acts as if it were issued internally two cycles later.
- R10: After reset, `buf_o` is 0, `busy_o` is 0, `err_o` is 0 and the total is 0.
- R11: The upper counter wraps modulo 2^24. A borrow from a total of 0 gives an upper counter of 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Accumulate enable for this cycle's sample |
| code_i | input | 3 | Sample code {sign, magnitude, valid} |
| ld_int_i | input | 1 | Internal load command |
| ld_ext_i | input | 1 | External load command, delayed two cycles |
| ld_sel_ext_i | input | 1 | 1 selects the external load source |
| clr_int_i | input | 1 | Internal clear command |
| clr_ext_i | input | 1 | External clear command, delayed two cycles |
| clr_sel_ext_i | input | 1 | 1 selects the external clear source |
| buf_o | output | 24 | Snapshot buffer of the upper counter |
| busy_o | output | 1 | Upper counter unsettled after a carry |
| err_o | output | 1 | Sticky flag for an illegal sample code |

## Verification
A wrong low-section value is hidden until it changes where a carry happens. The first sign at the ports is a `busy_o` pulse that starts one cycle early or late. The upper counter is seen only through `buf_o`, so a wrong upper count, a lost clear or a bad wrap shows at the edge after the next executed load. A mistake in deferring loads shows as a change on `buf_o` while `busy_o` is high, or as a missing change on the first free edge. A reference model compared on every clock catches any of these within one cycle of its first visible effect.

// File: rtl/lag_accum_pkg.sv
package lag_accum_pkg;
  typedef struct packed {
    logic sgn;
    logic mag;
    logic vld;
  } smp_code_t;

  localparam logic [2:0] CODE_ILLEGAL = 3'b000;
endpackage

// File: rtl/sample_decoder.sv
module sample_decoder
  import lag_accum_pkg::*;
(
  input  logic [2:0]        code_i,
  output logic signed [2:0] inc_o,
  output logic              step_ok_o,
  output logic              illegal_o
);
  smp_code_t c;
  assign c = smp_code_t'(code_i);

  always_comb begin
    inc_o = c.mag ? 3'sd3 : 3'sd1;
    if (c.sgn) inc_o = -inc_o;
  end

  assign step_ok_o = c.vld;
  assign illegal_o = (code_i == CODE_ILLEGAL);
endmodule

// File: rtl/cmd_source.sv
module cmd_source #(
  parameter int unsigned DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_i,
  input  logic ext_i,
  input  logic sel_ext_i,
  output logic cmd_o
);
  logic ext_d;

  generate
    if (DLY == 0) begin : g_nodly
      assign ext_d = ext_i;
    end else begin : g_dly
      logic [DLY-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else if (DLY == 1) pipe_q <= ext_i;
        else pipe_q <= {pipe_q[DLY-2:0], ext_i};
      end
      assign ext_d = pipe_q[DLY-1];
    end
  endgenerate

  assign cmd_o = sel_ext_i ? ext_d : int_i;
endmodule

// File: rtl/accum_core.sv
module accum_core #(
  parameter int unsigned HI_W   = 24,
  parameter int unsigned LO_W   = 3,
  parameter int unsigned SETTLE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic signed [2:0] inc_i,
  input  logic              clr_go_i,
  output logic [HI_W-1:0]   hi_o,
  output logic              busy_o
);
  localparam int unsigned SUM_W = LO_W + 2;
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);

  logic [LO_W-1:0]         lo_q;
  logic [HI_W-1:0]         hi_q;
  logic [CNT_W-1:0]        cnt_q;
  logic signed [SUM_W-1:0] sum;
  logic signed [1:0]       carry;
  logic [HI_W-1:0]         carry_ext, hi_base, hi_n;
  logic                    carry_nz;

  always_comb begin
    sum       = $signed({2'b00, lo_q}) + $signed({{(SUM_W-3){inc_i[2]}}, inc_i});
    carry     = sum[SUM_W-1:LO_W];
    carry_ext = {{(HI_W-2){carry[1]}}, carry};
    carry_nz  = step_i && (carry != 2'sb00);
    hi_base   = clr_go_i ? '0 : hi_q;
    hi_n      = hi_base + (step_i ? carry_ext : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (step_i) lo_q <= sum[LO_W-1:0];
      hi_q <= hi_n;
      if (carry_nz)          cnt_q <= CNT_W'(SETTLE);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign hi_o   = hi_q;
  assign busy_o = (cnt_q != '0);

  // R4
  carry_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_nz |=> busy_o);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_go_i) |=> ($stable(hi_q) && $stable(lo_q)));

  // R5
  clr_lo_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_go_i && !step_i) |=> ((hi_q == '0) && $stable(lo_q)));
endmodule

// File: rtl/snapshot_ctrl.sv
module snapshot_ctrl #(
  parameter int unsigned HI_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_cmd_i,
  input  logic            clr_cmd_i,
  input  logic            busy_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            clr_go_o,
  output logic [HI_W-1:0] buf_o
);
  logic            ld_pend_q, clr_pend_q;
  logic            ld_want, ld_go, clr_want, ld_hold;
  logic [HI_W-1:0] buf_q;

  always_comb begin
    ld_want  = ld_cmd_i | ld_pend_q;
    ld_hold  = ld_want & busy_i;
    ld_go    = ld_want & ~busy_i;
    clr_want = clr_cmd_i | clr_pend_q;
    clr_go_o = clr_want & ~ld_hold;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q  <= 1'b0;
      clr_pend_q <= 1'b0;
      buf_q      <= '0;
    end else begin
      ld_pend_q  <= ld_hold;
      clr_pend_q <= clr_want & ld_hold;
      if (ld_go) buf_q <= hi_i;
    end
  end

  assign buf_o = buf_q;

  // R7
  no_ld_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(buf_q));

  // R8
  clr_after_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_go_o && ld_pend_q) |-> !busy_i);
endmodule

// File: rtl/lag_accum_top.sv
module lag_accum_top #(
  parameter int unsigned HI_W    = 24,
  parameter int unsigned LO_W    = 3,
  parameter int unsigned SETTLE  = 2,
  parameter int unsigned EXT_DLY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_en_i,
  input  logic [2:0]      code_i,
  input  logic            ld_int_i,
  input  logic            ld_ext_i,
  input  logic            ld_sel_ext_i,
  input  logic            clr_int_i,
  input  logic            clr_ext_i,
  input  logic            clr_sel_ext_i,
  output logic [HI_W-1:0] buf_o,
  output logic            busy_o,
  output logic            err_o
);
  logic signed [2:0] inc;
  logic              step_ok, illegal, step;
  logic              ld_cmd, clr_cmd, clr_go;
  logic [HI_W-1:0]   hi;
  logic              err_q;

  sample_decoder u_dec (
    .code_i   (code_i),
    .inc_o    (inc),
    .step_ok_o(step_ok),
    .illegal_o(illegal)
  );

  cmd_source #(.DLY(EXT_DLY)) u_ld_src (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .int_i(ld_int_i), .ext_i(ld_ext_i), .sel_ext_i(ld_sel_ext_i),
    .cmd_o(ld_cmd)
  );

  cmd_source #(.DLY(EXT_DLY)) u_clr_src (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .int_i(clr_int_i), .ext_i(clr_ext_i), .sel_ext_i(clr_sel_ext_i),
    .cmd_o(clr_cmd)
  );

  assign step = acc_en_i & step_ok;

  accum_core #(.HI_W(HI_W), .LO_W(LO_W), .SETTLE(SETTLE)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .inc_i   (inc),
    .clr_go_i(clr_go),
    .hi_o    (hi),
    .busy_o  (busy_o)
  );

  snapshot_ctrl #(.HI_W(HI_W)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_cmd_i (ld_cmd),
    .clr_cmd_i(clr_cmd),
    .busy_i   (busy_o),
    .hi_i     (hi),
    .clr_go_o (clr_go),
    .buf_o    (buf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (acc_en_i && illegal) err_q <= 1'b1;
  end

  assign err_o = err_q;

  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: tb/sim_lag_accum_top.sv
`timescale 1ns/1ps
module sim_lag_accum_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_en_i = 1'b0;
  logic [2:0]  code_i = 3'b000;
  logic        ld_int_i = 1'b0, ld_ext_i = 1'b0, ld_sel_ext_i = 1'b0;
  logic        clr_int_i = 1'b0, clr_ext_i = 1'b0, clr_sel_ext_i = 1'b0;
  logic [23:0] buf_o;
  logic        busy_o, err_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 1'b0;

  lag_accum_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .code_i(code_i),
    .ld_int_i(ld_int_i), .ld_ext_i(ld_ext_i), .ld_sel_ext_i(ld_sel_ext_i),
    .clr_int_i(clr_int_i), .clr_ext_i(clr_ext_i), .clr_sel_ext_i(clr_sel_ext_i),
    .buf_o(buf_o), .busy_o(busy_o), .err_o(err_o)
  );

  always #2.5 clk_i = ~clk_i;

  // reference model state
  int lo_m, hi_m, buf_m, settle_m;
  bit err_m, ldp_m, clp_m;
  bit le1, le2, ce1, ce2;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      lo_m = 0; hi_m = 0; buf_m = 0; settle_m = 0; err_m = 0;
      ldp_m = 0; clp_m = 0; le1 = 0; le2 = 0; ce1 = 0; ce2 = 0;
    end else begin
      bit ldc, clc, bsy, ldw, clw, hold;
      int inc, s, c;
      ldc  = ld_sel_ext_i ? le2 : ld_int_i;
      clc  = clr_sel_ext_i ? ce2 : clr_int_i;
      bsy  = settle_m > 0;
      ldw  = ldc || ldp_m;
      clw  = clc || clp_m;
      hold = ldw && bsy;
      if (ldw && !bsy) buf_m = hi_m;
      if (clw && !hold) hi_m = 0;
      c = 0;
      if (acc_en_i && code_i[0]) begin
        inc = code_i[1] ? 3 : 1;
        if (code_i[2]) inc = -inc;
        s = lo_m + inc;
        c = (s < 0) ? -1 : ((s > 7) ? 1 : 0);
        lo_m = s - 8 * c;
        hi_m = (hi_m + c + 16777216) % 16777216;
      end
      if (c != 0) settle_m = 2;
      else if (settle_m > 0) settle_m = settle_m - 1;
      if (acc_en_i && code_i == 3'b000) err_m = 1;
      ldp_m = hold;
      clp_m = clw && hold;
      le2 = le1; le1 = ld_ext_i;
      ce2 = ce1; ce1 = clr_ext_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && cmp_on) begin
      chk("R6 model buffer", int'(buf_o), buf_m);
      chk("R4 model busy", int'(busy_o), settle_m > 0 ? 1 : 0);
      chk("R3 model err", int'(err_o), int'(err_m));
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick(); @(negedge clk_i); endtask
  task automatic idle(input int n);
    acc_en_i = 0;
    repeat (n) tick();
  endtask
  task automatic acc(input logic [2:0] cd, input int n);
    acc_en_i = 1; code_i = cd;
    repeat (n) tick();
    acc_en_i = 0;
  endtask
  task automatic ld_pulse();
    ld_int_i = 1; tick(); ld_int_i = 0;
  endtask
  task automatic clr_pulse();
    clr_int_i = 1; tick(); clr_int_i = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    // R10 reset state
    chk("R10 buf", int'(buf_o), 0);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 err", int'(err_o), 0);
    cmp_on = 1;

    // R1: +3 x3 = 9 -> upper 1
    acc(3'b011, 3); idle(3); ld_pulse();
    chk("R1 plus3 sum", int'(buf_o), 1);
    acc(3'b111, 1); idle(3); ld_pulse();       // 6
    chk("R1 minus3 sum", int'(buf_o), 0);
    acc(3'b001, 2); idle(3); ld_pulse();       // 8
    chk("R1 plus1 sum", int'(buf_o), 1);

    // R2: disabled and invalid samples ignored
    acc_en_i = 0; code_i = 3'b011; repeat (8) tick();
    acc(3'b010, 3); acc(3'b100, 3); acc(3'b110, 3);
    chk("R2 busy", int'(busy_o), 0);
    idle(1); ld_pulse();
    chk("R2 ignored", int'(buf_o), 1);

    // R3: illegal sets sticky flag, no accumulate
    acc(3'b000, 1);
    chk("R3 err set", int'(err_o), 1);
    idle(2);
    chk("R3 err sticky", int'(err_o), 1);
    ld_pulse();
    chk("R3 no add", int'(buf_o), 1);

    // R5: clear upper only, low kept at 5
    acc(3'b011, 1); acc(3'b001, 2); idle(3);
    clr_pulse(); ld_pulse();
    chk("R5 upper zero", int'(buf_o), 0);
    acc(3'b011, 1); idle(3); ld_pulse();
    chk("R5 low kept", int'(buf_o), 1);

    // R7: load during busy deferred (total 8 -> 7)
    acc_en_i = 1; code_i = 3'b101; tick();
    acc_en_i = 0; ld_int_i = 1; tick(); ld_int_i = 0;
    chk("R7 busy", int'(busy_o), 1);
    chk("R7 held", int'(buf_o), 1);
    tick();
    chk("R4 busy falls", int'(busy_o), 0);
    chk("R7 still held", int'(buf_o), 1);
    tick();
    chk("R7 executed", int'(buf_o), 0);

    // R8: clear with waiting load goes after load (total 7 -> 8)
    acc_en_i = 1; code_i = 3'b001; tick();
    acc_en_i = 0; ld_int_i = 1; clr_int_i = 1; tick();
    ld_int_i = 0; clr_int_i = 0;
    chk("R8 wait1", int'(buf_o), 0);
    tick();
    chk("R8 wait2", int'(buf_o), 0);
    tick();
    chk("R8 pre-clear value", int'(buf_o), 1);
    idle(1); ld_pulse();
    chk("R8 cleared", int'(buf_o), 0);

    // R11: borrow from zero wraps
    acc(3'b101, 1); idle(3); ld_pulse();
    chk("R11 wrap", int'(buf_o), 24'hFFFFFF);

    // R9: external source with delay, internal ignored
    acc(3'b001, 1); idle(3);
    ld_sel_ext_i = 1; ld_pulse(); idle(3);
    chk("R9 int ignored", int'(buf_o), 24'hFFFFFF);
    ld_ext_i = 1; tick(); ld_ext_i = 0;
    chk("R9 d0", int'(buf_o), 24'hFFFFFF);
    tick();
    chk("R9 d1", int'(buf_o), 24'hFFFFFF);
    tick();
    chk("R9 d2", int'(buf_o), 0);
    ld_sel_ext_i = 0;

    // random mix checked against model
    for (int i = 0; i < 4000; i++) begin
      acc_en_i  = ($urandom_range(0, 9) < 7);
      code_i    = 3'($urandom_range(0, 7));
      if (code_i == 3'b000 && $urandom_range(0, 9) != 0) code_i = 3'b011;
      ld_int_i  = ($urandom_range(0, 19) == 0);
      clr_int_i = ($urandom_range(0, 29) == 0);
      ld_ext_i  = ($urandom_range(0, 19) == 0);
      clr_ext_i = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 99) == 0) ld_sel_ext_i = ~ld_sel_ext_i;
      if ($urandom_range(0, 99) == 0) clr_sel_ext_i = ~clr_sel_ext_i;
      tick();
    end
    idle(4);
    summary();
    $finish;
  end
endmodule